// File: doc/BRIEF.md
# Dual-Protocol Configuration Register Port

This block holds a small bank of 8-bit configuration registers and lets a host reach them through either of two protocols that share the same pins. In serial form, the shared select pin is an active-high enable, a second pin is the serial clock and a third is serial data in. Read-back data leaves on a single serial output. In parallel form, the select pin is an active-low strobe, the data pin becomes a data/address phase select, the clock pin becomes read/not-write, and an 8-bit bus carries the address, the write data or the read-back data.

The protocol is sampled from the select pin at the moment reset is released: low selects serial and high selects parallel. It then stays fixed until the next reset. Every register value is brought out on a flat output vector so that the logic it controls can use it directly. All pins are sampled on the system clock. Edges of the enable/strobe and of the serial clock are found by comparing each pin with its value in the previous cycle.

Top module: `cfg_regport`

## Requirements
- R1: The protocol is the level of `sel_i` in the last clock cycle with `rst_n` low: 0 selects serial and 1 selects parallel. It does not change while `rst_n` stays high.
- R2: While `rst_n` is low, every register and the stored parallel address become 0, and `sdo_oe`, `bus_oe` and the serial read state are cleared.
- R3: A serial frame is 16 bits, shifted in MSB first on rising `sck_rnw_i` while the enable is high. Its bits are address[5:0] in bits 15..10, read flag in bit 9, a reserved bit 8, and data in bits 7..0. On the falling edge of the enable, a frame with the read flag at 0 writes the data to the register at that address.
- R4: A serial frame in which the enable falls after any count of rising clocks other than 16 changes no register and starts no read.
- R5: After a frame with the read flag at 1, `sdo_o` presents bit 7 of the addressed register. Each falling edge of `sck_rnw_i` then advances to the next lower bit, so the byte comes out MSB first.
- R6: `sdo_oe` is high only in serial mode, between the commit of a read frame and the next rise of the enable, and only while `oe_n_i` is 0.
- R7: In parallel mode, a rising strobe edge with `sdi_dna_i` = 0 and `sck_rnw_i` = 0 stores `bus_i[5:0]` as the current address.
- R8: In parallel mode, a rising strobe edge with `sdi_dna_i` = 1 and `sck_rnw_i` = 0 writes `bus_i` to the current address. The address is kept, so repeated data phases hit the same register.
- R9: In parallel mode, `bus_oe` is 1 exactly while `sck_rnw_i` = 1, the strobe is low and `oe_n_i` = 0. `bus_o` then shows the register at the current address. A strobe with `sck_rnw_i` = 1 writes nothing.
- R10: Addresses at or above `NREG` are not implemented. Writes to them are ignored, and they read back as 0 on both protocols.
- R11: The output of the protocol not selected stays off: `bus_oe` is 0 in serial mode and `sdo_oe` is 0 in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; its release latches the protocol |
| sel_i | input | 1 | Serial enable (active high) or parallel strobe (active low) |
| sck_rnw_i | input | 1 | Serial clock, or parallel read/not-write |
| sdi_dna_i | input | 1 | Serial data in, or parallel data (1) / address (0) select |
| oe_n_i | input | 1 | Active-low output enable for both read paths |
| bus_i | input | 8 | Parallel address or write data |
| bus_o | output | 8 | Parallel read-back data |
| bus_oe | output | 1 | Drive enable for the parallel read-back lane |
| sdo_o | output | 1 | Serial read-back data |
| sdo_oe | output | 1 | Drive enable for the serial read-back pin |
| regs_o | output | NREG*8 | All register values, register 0 in the low byte |

## Verification
The bench builds the block with `NREG` = 6. This leaves 58 of the 64 frame addresses unimplemented, so random serial and parallel traffic often lands outside the bank and exercises the ignored-write and zero-read paths. The bench resets the block twice, once with the select pin low and once high, so that both protocols are tested in the same run. In the second reset the pin is changed while reset is held, which shows that only the level at release counts.

// File: rtl/cfg_regport.sv
module cfg_regport #(
  parameter int NREG = 8,
  parameter int AW   = 6,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              sck_rnw_i,
  input  logic              sdi_dna_i,
  input  logic              oe_n_i,
  input  logic [DW-1:0]     bus_i,
  output logic [DW-1:0]     bus_o,
  output logic              bus_oe,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int FW = AW + 2 + DW;
  localparam int CW = $clog2(FW + 2);

  logic          par_mode, sel_q, sck_q, rd_q;
  logic [AW-1:0] addr_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] out_q;
  logic [DW-1:0] regs [NREG];

  wire sel_rise = sel_i & ~sel_q;
  wire sel_fall = ~sel_i & sel_q;
  wire en_rise  = ~par_mode & sel_rise;
  wire en_fall  = ~par_mode & sel_fall;
  wire stb_rise = par_mode & sel_rise;
  wire sck_rise = sck_rnw_i & ~sck_q;
  wire sck_fall = ~sck_rnw_i & sck_q;

  wire [AW-1:0] f_addr = sh_q[FW-1 -: AW];
  wire          f_rd   = sh_q[DW+1];
  wire [DW-1:0] f_data = sh_q[DW-1:0];
  wire          commit = en_fall && (cnt_q == CW'(FW));

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++)
      if (a == AW'(i)) v = regs[i];
    return v;
  endfunction

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = addr_q;
    wr_data = bus_i;
    if (stb_rise && sdi_dna_i && !sck_rnw_i) begin
      wr_en = 1'b1;
    end else if (commit && !f_rd) begin
      wr_en   = 1'b1;
      wr_addr = f_addr;
      wr_data = f_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) par_mode <= sel_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= sel_i;
      sck_q  <= 1'b0;
      addr_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      out_q  <= '0;
      rd_q   <= 1'b0;
    end else begin
      sel_q <= sel_i;
      sck_q <= sck_rnw_i;
      if (stb_rise && !sdi_dna_i && !sck_rnw_i) addr_q <= bus_i[AW-1:0];
      if (en_rise) begin
        cnt_q <= '0;
        rd_q  <= 1'b0;
      end else if (!par_mode && sel_i && sck_rise) begin
        sh_q <= {sh_q[FW-2:0], sdi_dna_i};
        if (cnt_q <= CW'(FW)) cnt_q <= cnt_q + 1'b1;
      end
      if (commit && f_rd) begin
        out_q <= rd_val(f_addr);
        rd_q  <= 1'b1;
      end else if (rd_q && sck_fall) begin
        out_q <= {out_q[DW-2:0], 1'b0};
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (wr_en && wr_addr == AW'(g)) regs[g] <= wr_data;
    end
    assign regs_o[g*DW +: DW] = regs[g];
  end

  assign bus_oe = par_mode & sck_rnw_i & ~sel_i & ~oe_n_i;
  assign bus_o  = rd_val(addr_q);
  assign sdo_o  = out_q[DW-1];
  assign sdo_oe = ~par_mode & rd_q & ~oe_n_i;

  a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(par_mode));

  a_r3_write_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$stable(regs_o) |-> $past(stb_rise || en_fall));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FW + 1));

  a_r5_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && sdo_oe && $past(sdo_oe) && !$past(sck_fall) && !$past(en_fall)
      |-> $stable(sdo_o));

  a_r11_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && sdo_oe));
endmodule

// File: tb/sim_cfg_regport.sv
module sim_cfg_regport;
  localparam int NR = 6;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, sel = 0, sck = 0, sdi = 0, oe_n = 0;
  logic [7:0] bus_i = 0, bus_o;
  logic bus_oe, sdo_o, sdo_oe;
  logic [NR*8-1:0] regs_o;
  logic [7:0] mdl [NR];
  int runs = 0, fails = 0;

  always #(TCLK/2) clk = ~clk;

  cfg_regport #(.NREG(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_rnw_i(sck), .sdi_dna_i(sdi),
    .oe_n_i(oe_n), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .regs_o(regs_o));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] packed_mdl();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    return (a < NR) ? mdl[a] : 8'h00;
  endfunction

  task automatic do_reset(input logic early, input logic late);
    rst_n = 0; sel = early; sck = 0; sdi = 0;
    tick(3);
    sel = late;
    tick(2);
    rst_n = 1;
    tick(2);
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
  endtask

  task automatic ser_frame(input logic [15:0] f, input int nbits);
    sel = 1; tick(2);
    for (int i = 0; i < nbits; i++) begin
      sdi = f[15-i]; tick(1);
      sck = 1; tick(2);
      sck = 0; tick(1);
    end
    sel = 0; tick(3);
  endtask

  task automatic ser_write(input logic [5:0] a, input logic [7:0] d);
    ser_frame({a, 1'b0, 1'b0, d}, 16);
    if (a < NR) mdl[a] = d;
  endtask

  task automatic ser_read(input logic [5:0] a, output logic [7:0] v, output logic oe_ok);
    ser_frame({a, 1'b1, 1'b0, 8'h00}, 16);
    oe_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (!sdo_oe || bus_oe) oe_ok = 1'b0;
      v[7-i] = sdo_o;
      sck = 1; tick(2);
      sck = 0; tick(2);
    end
  endtask

  task automatic par_phase(input logic dna, input logic [7:0] d);
    sck = 0; sdi = dna; bus_i = d; tick(2);
    sel = 0; tick(1);
    chk("R9 no drive during write", {62'd0, bus_oe, sdo_oe}, 64'd0);
    tick(1);
    sel = 1; tick(2);
  endtask

  task automatic par_read(output logic [7:0] v, output logic oe);
    sck = 1; sdi = 1; tick(1);
    sel = 0; tick(2);
    v = bus_o; oe = bus_oe;
    sel = 1; tick(1);
    sck = 0; tick(2);
  endtask

  initial begin
    logic [7:0] v;
    logic ok;
    void'($urandom(32'd4242));
    oe_n = 0;

    do_reset(1'b0, 1'b0);
    chk("R2 regs cleared", regs_o, 0);
    chk("R2 outputs off", {62'd0, bus_oe, sdo_oe}, 64'd0);

    ser_write(6'd2, 8'hA5);
    chk("R3 serial write", regs_o, packed_mdl());
    ser_write(6'd0, 8'h3C);
    ser_write(6'd5, 8'hFF);
    chk("R3 serial write lo/hi", regs_o, packed_mdl());
    ser_write(6'd6, 8'h77);
    ser_write(6'd63, 8'h11);
    chk("R10 serial oob write ignored", regs_o, packed_mdl());

    for (int k = 0; k < 25; k++) begin
      logic [5:0] a;
      a = 6'($urandom_range(0, 11));
      if (k % 5 == 4) a = 6'($urandom);
      ser_write(a, 8'($urandom));
      chk("R3 random serial write", regs_o, packed_mdl());
    end

    ser_frame({6'd1, 1'b0, 1'b0, 8'hEE}, 15);
    chk("R4 short frame ignored", regs_o, packed_mdl());
    chk("R4 short frame no read", {63'd0, sdo_oe}, 64'd0);
    ser_frame({6'd1, 1'b0, 1'b0, 8'hEE}, 17);
    chk("R4 long frame ignored", regs_o, packed_mdl());

    for (int a = 0; a < 8; a++) begin
      ser_read(6'(a), v, ok);
      chk("R5 serial readback", v, exp_rd(6'(a)));
      chk("R6 sdo_oe during read / R11 bus off", {63'd0, ok}, 64'd1);
    end
    ser_read(6'd40, v, ok);
    chk("R10 serial oob reads zero", v, 0);

    ser_frame({6'd2, 1'b1, 1'b0, 8'h00}, 16);
    chk("R5 first bit is msb", {63'd0, sdo_o}, {63'd0, mdl[2][7]});
    oe_n = 1; tick(1);
    chk("R6 oe_n gates sdo", {63'd0, sdo_oe}, 64'd0);
    oe_n = 0; tick(1);
    chk("R6 sdo back on", {63'd0, sdo_oe}, 64'd1);
    sel = 1; tick(2);
    chk("R6 enable rise ends read", {63'd0, sdo_oe}, 64'd0);
    sel = 0; tick(2);

    do_reset(1'b0, 1'b1);
    chk("R2 regs cleared again", regs_o, 0);
    par_phase(1'b1, 8'h5A);
    chk("R1 parallel mode, R2 address zero", regs_o, {{(NR*8-8){1'b0}}, 8'h5A});
    mdl[0] = 8'h5A;
    chk("R11 no sdo in parallel", {63'd0, sdo_oe}, 64'd0);

    par_phase(1'b0, 8'd3);
    par_phase(1'b1, 8'h12); mdl[3] = 8'h12;
    chk("R7 R8 parallel write", regs_o, packed_mdl());
    par_phase(1'b1, 8'h34); mdl[3] = 8'h34;
    chk("R8 address kept", regs_o, packed_mdl());
    par_phase(1'b0, 8'd9);
    par_phase(1'b1, 8'hC3);
    chk("R10 parallel oob write ignored", regs_o, packed_mdl());
    par_read(v, ok);
    chk("R10 parallel oob reads zero", {55'd0, ok, v}, {55'd0, 1'b1, 8'h00});

    for (int k = 0; k < 30; k++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = 6'($urandom_range(0, 9));
      d = 8'($urandom);
      par_phase(1'b0, {2'b00, a});
      par_phase(1'b1, d);
      if (a < NR) mdl[a] = d;
      chk("R8 random parallel write", regs_o, packed_mdl());
      par_read(v, ok);
      chk("R9 parallel readback", {55'd0, ok, v}, {55'd0, 1'b1, exp_rd(a)});
      chk("R9 read writes nothing", regs_o, packed_mdl());
    end

    oe_n = 1;
    par_read(v, ok);
    chk("R9 oe_n gates bus", {63'd0, ok}, 64'd0);
    oe_n = 0;
    sck = 1; tick(2);
    chk("R9 no drive with strobe high", {63'd0, bus_oe}, 64'd0);
    sck = 0; tick(2);
    chk("R1 R11 mode held", {63'd0, sdo_oe}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    runs++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule